// File: doc/BRIEF.md
# Command Ring Fetch Controller

This block is the hardware half of a circular command queue that software fills. Software puts 32-bit commands into a small internal ring memory and then publishes a write pointer. While the run bit is set, the block fetches each pending entry and hands it to a downstream link interface over a valid/ready handshake. It advances a hardware-owned read pointer by one for every command the link accepts.

Software uses a register port with four registers. The write pointer is at select 0, bits 7:0. The read pointer is at select 1, with the pointer in bits 7:0 and a reset flag in bit 15. The control register is at select 2, with the run bit in bit 0. The ring-size code is at select 3, in bits 1:0. Software owns the ring memory's write port. The read pointer is cleared by a two-phase reset: a write that sets bit 15, followed by a write of zero. When the run bit is cleared, it keeps reading back as 1 until a command already on offer to the link has been accepted. While the controller is held in link reset, both pointer registers read as all ones, so that software can tell a dead controller from a live one.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, every register reads 0 and `cmdValid` is low.
- R2: The size register stores bits 1:0 of a write and reads them back. Code 2 means a ring of 256 entries, which is the fixed depth.
- R3: No command is offered while the run bit is clear. Once the run bit is set, the first command offered after a pointer reset is the entry at slot 1.
- R4: Commands are offered strictly in slot order, from read pointer + 1 up to the write pointer, and never beyond it. With both pointers equal, `cmdValid` stays low.
- R5: The read pointer rises by one for each accepted command and wraps from 255 to 0.
- R6: While `cmdValid` is high and `cmdReady` is low, `cmdValid` and `cmdData` hold their values.
- R7: `cmdCodec` carries bits 31:28 of the offered command, unchanged.
- R8: A write to the read-pointer register with bit 15 set clears the pointer and makes the register read 0x8000. Fetching stays blocked until software writes 0, after which the register reads exactly 0x0000.
- R9: After the run bit is cleared, it reads 1 until any offered command has been accepted. It then reads 0, and no further command is fetched.
- R10: While `linkReset` is high, both pointer registers read 0xFFFF. The control and size registers read normally.
- R11: The write pointer reads back as written. A read-pointer write with bit 15 clear has no effect on the pointer while the reset flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkReset | input | 1 | Controller held in link reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for the current select, combinational |
| ramWrEn | input | 1 | Ring memory write strobe |
| ramWrAddr | input | 8 | Ring memory slot |
| ramWrData | input | 32 | Ring memory write data |
| cmdValid | output | 1 | Command on offer to the link |
| cmdReady | input | 1 | Link accepts the command |
| cmdData | output | 32 | Offered command |
| cmdCodec | output | 4 | Codec address of the offered command |

## Verification
Register writes take effect at the clock edge that samples them, and register reads are combinational. The bench therefore drives each write and reads the result back at the next falling edge. A fetch is issued one edge after the run bit and a pending entry are both present, and `cmdValid` rises at that same edge. After an acceptance edge, `cmdValid` is low for exactly one cycle before the next entry appears. The bench waits for `cmdValid` at falling edges, and compares data and pointer readbacks only at the falling edge after the edge that must change them. Checks that something has not happened hold for several cycles, which is longer than the one-cycle fetch delay.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;

  // control to datapath strobes
  typedef struct packed {
    logic fetch;    // read next slot into the command register
    logic advance;  // command accepted, move read pointer
  } ringStrobe_t;

  typedef enum logic [1:0] {
    SEL_WPTR = 2'd0,
    SEL_RPTR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_SIZE = 2'd3
  } regSel_e;

endpackage

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import ring_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        canFetch,
  input  logic        cmdReady,
  output ringStrobe_t stb,
  output logic        cmdValid,
  output logic        busy
);

  typedef enum logic {ST_IDLE, ST_OFFER} fetchState_e;
  fetchState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    stb.fetch   = 1'b0;
    stb.advance = 1'b0;
    unique case (state)
      ST_IDLE: if (canFetch) begin
        stb.fetch = 1'b1;
        stateNext = ST_OFFER;
      end
      ST_OFFER: if (cmdReady) begin
        stb.advance = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdValid = (state == ST_OFFER);
  assign busy     = (state == ST_OFFER);

endmodule

// File: rtl/ring_fetch_dpath.sv
module ring_fetch_dpath
  import ring_fetch_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int SIZE_W = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkReset,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              ramWrEn,
  input  logic [PTR_W-1:0]  ramWrAddr,
  input  logic [DATA_W-1:0] ramWrData,
  input  ringStrobe_t       stb,
  input  logic              busy,
  output logic [DATA_W-1:0] cmdData,
  output logic              canFetch,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [PTR_W-1:0]  wrPtr,
  output logic              runStatus
);

  localparam int RST_BIT = REG_W - 1;

  logic [DATA_W-1:0] ringMem [DEPTH];
  logic              runReq;
  logic              rpRstFlag;
  logic [SIZE_W-1:0] sizeCode;
  logic              selWp, selRp, selCtrl, selSize;

  assign selWp   = regWrEn && (regAddr == SEL_WPTR);
  assign selRp   = regWrEn && (regAddr == SEL_RPTR);
  assign selCtrl = regWrEn && (regAddr == SEL_CTRL);
  assign selSize = regWrEn && (regAddr == SEL_SIZE);

  always_ff @(posedge clk) begin
    if (ramWrEn) ringMem[ramWrAddr] <= ramWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdData <= '0;
    end else if (stb.fetch) begin
      cmdData <= ringMem[rdPtr + PTR_W'(1)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      rpRstFlag <= 1'b0;
      runReq    <= 1'b0;
      sizeCode  <= '0;
    end else begin
      if (selWp)   wrPtr    <= regWrData[PTR_W-1:0];
      if (selCtrl) runReq   <= regWrData[0];
      if (selSize) sizeCode <= regWrData[SIZE_W-1:0];
      if (selRp && regWrData[RST_BIT]) rdPtr <= '0;
      else if (stb.advance)            rdPtr <= rdPtr + PTR_W'(1);
      if (selRp) begin
        if (regWrData[RST_BIT])  rpRstFlag <= 1'b1;
        else if (rpRstFlag)      rpRstFlag <= 1'b0;
      end
    end
  end

  assign canFetch  = runReq && !rpRstFlag && (rdPtr != wrPtr);
  assign runStatus = runReq || busy;

  always_comb begin
    unique case (regSel_e'(regAddr))
      SEL_WPTR: regRdData = linkReset ? '1 : REG_W'(wrPtr);
      SEL_RPTR: regRdData = linkReset ? '1 :
                  {rpRstFlag, {(REG_W-1-PTR_W){1'b0}}, rdPtr};
      SEL_CTRL: regRdData = REG_W'(runStatus);
      SEL_SIZE: regRdData = REG_W'(sizeCode);
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import ring_fetch_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 16,
  parameter int CODEC_W = 4,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkReset,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              ramWrEn,
  input  logic [PTR_W-1:0]  ramWrAddr,
  input  logic [DATA_W-1:0] ramWrData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [DATA_W-1:0] cmdData,
  output logic [CODEC_W-1:0] cmdCodec
);

  ringStrobe_t      stb;
  logic             busy;
  logic             canFetch;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic             runStatus;

  ring_fetch_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .canFetch (canFetch),
    .cmdReady (cmdReady),
    .stb      (stb),
    .cmdValid (cmdValid),
    .busy     (busy)
  );

  ring_fetch_dpath #(
    .DEPTH (DEPTH), .DATA_W (DATA_W), .REG_W (REG_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .linkReset (linkReset),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ramWrEn   (ramWrEn),
    .ramWrAddr (ramWrAddr),
    .ramWrData (ramWrData),
    .stb       (stb),
    .busy      (busy),
    .cmdData   (cmdData),
    .canFetch  (canFetch),
    .rdPtr     (rdPtr),
    .wrPtr     (wrPtr),
    .runStatus (runStatus)
  );

  assign cmdCodec = cmdData[DATA_W-1 -: CODEC_W];

endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int PTR_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [DATA_W-1:0] cmdData,
  input logic [PTR_W-1:0]  rdPtr,
  input logic [PTR_W-1:0]  wrPtr,
  input logic              runStatus
);

  logic rpRstWr;
  assign rpRstWr = regWrEn && (regAddr == 2'd1) && regWrData[REG_W-1];

  // R6
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && !rpRstWr |=> rdPtr == $past(rdPtr) + PTR_W'(1));

  // R8
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rpRstWr |=> rdPtr == '0);

  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> rdPtr != wrPtr);

  // R9
  drain_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runStatus) |-> !cmdValid);

endmodule

bind cmd_ring_fetch ring_fetch_chk #(
  .DATA_W (DATA_W), .REG_W (REG_W), .PTR_W (PTR_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdData   (cmdData),
  .rdPtr     (rdPtr),
  .wrPtr     (wrPtr),
  .runStatus (runStatus)
);

// File: tb/test_cmd_ring_fetch.sv
module test_cmd_ring_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkReset = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        ramWrEn = 1'b0;
  logic [7:0]  ramWrAddr = '0;
  logic [31:0] ramWrData = '0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic [3:0]  cmdCodec;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmd_ring_fetch i_cmd_ring_fetch (.*);

  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h1000_0011, 32'h2ABC_0022, 32'hF123_4567,
    32'h0000_0000, 32'h7FFF_FFFF, 32'hA5A5_5A5A
  };

  function automatic logic [31:0] slotData(input logic [7:0] s);
    return {s[3:0], 4'h5, 16'hC0DE ^ {8'h00, s}, s};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regChk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    regAddr = a;
    #1;
    check(regRdData == exp, tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic ramWr(input logic [7:0] a, input logic [31:0] d);
    ramWrEn = 1'b1; ramWrAddr = a; ramWrData = d;
    @(negedge clk);
    ramWrEn = 1'b0;
  endtask

  task automatic waitValid(input string tag);
    for (int i = 0; i < 40 && !cmdValid; i++) @(negedge clk);
    check(cmdValid, tag, 32'(cmdValid), 32'd1);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!cmdValid, tag, 32'(cmdValid), 32'd0);
    end
  endtask

  task automatic takeCmd(input logic [31:0] exp, input int stall, input string tag);
    waitValid(tag);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      // R6 held while not ready
      check(cmdValid && cmdData == exp, "R6 hold", cmdData, exp);
    end
    check(cmdData == exp, tag, cmdData, exp);
    // R7 codec field
    check(cmdCodec == exp[31:28], "R7 codec", 32'(cmdCodec), 32'(exp[31:28]));
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmdValid, "R1 valid", 32'(cmdValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    regChk(2'd0, 16'h0000, "R1 wptr");
    regChk(2'd1, 16'h0000, "R1 rptr");
    regChk(2'd2, 16'h0000, "R1 ctrl");
    regChk(2'd3, 16'h0000, "R1 size");

    // init sequence
    regWr(2'd3, 16'h0002);
    regChk(2'd3, 16'h0002, "R2 size code");
    regWr(2'd0, 16'h0000);
    regChk(2'd0, 16'h0000, "R11 wptr clear");
    regWr(2'd1, 16'h8000);
    regChk(2'd1, 16'h8000, "R8 reset flag");
    regWr(2'd1, 16'h0000);
    regChk(2'd1, 16'h0000, "R8 released");

    // table walk
    for (int i = 0; i < NVEC; i++) ramWr(8'(i + 1), VEC[i]);
    regWr(2'd0, 16'(NVEC));
    regChk(2'd0, 16'(NVEC), "R11 wptr readback");
    quiet(5, "R3 idle while stopped");
    regWr(2'd1, 16'h0005);
    regChk(2'd1, 16'h0000, "R11 rptr write ignored");
    regWr(2'd2, 16'h0001);
    for (int i = 0; i < NVEC; i++)
      takeCmd(VEC[i], (i % 2) * 2, "R3 R4 in-order command");
    quiet(5, "R4 stop at wptr");
    regChk(2'd1, 16'(NVEC), "R5 rptr count");

    // R10 link reset readback
    linkReset = 1'b1;
    regChk(2'd0, 16'hFFFF, "R10 wptr dead");
    regChk(2'd1, 16'hFFFF, "R10 rptr dead");
    regChk(2'd2, 16'h0001, "R10 ctrl normal");
    regChk(2'd3, 16'h0002, "R10 size normal");
    linkReset = 1'b0;

    // wrap through slot 255
    for (int s = NVEC + 1; s < 256 + 5; s++) ramWr(8'(s), slotData(8'(s)));
    regWr(2'd0, 16'h0004);
    for (int s = NVEC + 1; s < 256 + 5; s++)
      takeCmd(slotData(8'(s)), 0, "R5 wrap order");
    regChk(2'd1, 16'h0004, "R5 wrapped rptr");

    // R9 drain on stop
    ramWr(8'd5, 32'h3BAD_F00D);
    regWr(2'd0, 16'h0005);
    waitValid("R9 pending");
    regWr(2'd2, 16'h0000);
    regChk(2'd2, 16'h0001, "R9 run still busy");
    check(cmdValid, "R9 offer kept", 32'(cmdValid), 32'd1);
    check(cmdData == 32'h3BAD_F00D, "R9 data", cmdData, 32'h3BAD_F00D);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    regChk(2'd2, 16'h0000, "R9 run drained");
    regWr(2'd0, 16'h0006);
    quiet(6, "R9 no fetch after stop");

    // R8 reset flag blocks fetching
    regWr(2'd1, 16'h8000);
    regChk(2'd1, 16'h8000, "R8 flag set");
    regWr(2'd2, 16'h0001);
    quiet(6, "R8 blocked while flagged");
    regWr(2'd1, 16'h0000);
    regChk(2'd1, 16'h0000, "R8 reads zero");
    takeCmd(slotData(8'd1), 1, "R3 first slot after reset");
    regChk(2'd1, 16'h0001, "R5 step after restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule